// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block sits beside a processor core and decides, for every synchronous fault the core reports, which handler runs next. A fault arrives with a class: memory-management, bus, usage or hard. The block weighs that class against the per-class enable bits, the per-class configurable priorities, the current execution priority and the identity of the handler now running. It then picks either the fault's own handler or a hard fault. It flags every promotion to hard fault.

When a hard fault cannot preempt the running code, the block enters lockup and raises an output that stops instruction issue. Lockup ends on reset or on an NMI request. For memory-management and bus faults the block also holds the faulting address, with a valid bit, until software releases it. Execution, stacking and vector fetch stay outside the block; the core signals them with plain strobes.

Top module: `fault_escalation_ctrl`

## Requirements
- R1: After reset, handlerSel, escalated, lockup, forcedEsc, stackErr, memAddrValid and busAddrValid are all 0.
- R2: faultClass encodes 0 = memory-management, 1 = bus, 2 = usage, 3 = hard. The decision appears on the clock edge after the edge that samples faultReq. handlerSel is one-hot in that cycle, with bit0 memory-management, bit1 bus, bit2 usage and bit3 hard, unless lockup is entered. handlerSel is all zero in every cycle that does not follow an accepted fault.
- R3: activeHandler encodes 0 = thread, 1 = memory-management, 2 = bus, 3 = usage, 4 = hard, 5 = NMI, 6 = other exception. A configurable fault is dispatched to its own handler with escalated = 0 when three conditions hold: its enable bit is set, its 4-bit priority is numerically strictly less than curPrio, and activeHandler is not its own class.
- R4: A configurable fault raised while its own class's handler is active is escalated to hard fault (escalated = 1).
- R5: A configurable fault whose priority is numerically greater than or equal to curPrio is escalated to hard fault.
- R6: classEnable bit0 enables memory-management, bit1 bus, bit2 usage. A configurable fault whose enable bit is 0 is escalated to hard fault.
- R7: A bus fault with stackPush = 1 is never escalated. It selects the bus handler with escalated = 0 and sets the sticky stackErr. stackErr clears on the clrStackErr strobe; a set in the same cycle wins.
- R8: A hard fault, whether raised directly or by escalation, selects the hard handler whatever curPrio is. The exception is a hard fault while activeHandler is hard or NMI: then lockup goes to 1 and handlerSel stays 0.
- R9: While lockup is 1, faultReq is ignored: no selection, no address capture, no status change. lockup falls on the edge that samples nmiReq = 1, and on reset.
- R10: An accepted memory-management or bus fault loads faultAddr into that class's address register and sets its valid bit, but only if the valid bit was clear. A valid register holds until its clear strobe. Usage and hard faults capture nothing.
- R11: forcedEsc is set by every escalation and stays set until the clrForced strobe; a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| faultReq | input | 1 | Fault request strobe |
| faultClass | input | 2 | Class of the requested fault |
| faultAddr | input | ADDR_W | Address of the faulting access |
| stackPush | input | 1 | Fault raised during the stack push on bus-handler entry |
| classEnable | input | 3 | Per-class handler enables |
| prioMem | input | PRIO_W | Memory-management fault priority |
| prioBus | input | PRIO_W | Bus fault priority |
| prioUsage | input | PRIO_W | Usage fault priority |
| curPrio | input | PRIO_W | Current execution priority |
| activeHandler | input | 3 | Identity of the running handler |
| nmiReq | input | 1 | NMI request |
| clrForced | input | 1 | Write-one-to-clear for forcedEsc |
| clrStackErr | input | 1 | Write-one-to-clear for stackErr |
| clrMemAddr | input | 1 | Write-one-to-clear for memAddrValid |
| clrBusAddr | input | 1 | Write-one-to-clear for busAddrValid |
| handlerSel | output | 4 | One-hot selected handler |
| escalated | output | 1 | Decision promoted the fault to hard |
| lockup | output | 1 | Halts instruction issue |
| forcedEsc | output | 1 | Sticky escalation status |
| stackErr | output | 1 | Sticky stack-corrupt status |
| memAddr | output | ADDR_W | Captured memory-management fault address |
| memAddrValid | output | 1 | memAddr holds a capture |
| busAddr | output | ADDR_W | Captured bus fault address |
| busAddrValid | output | 1 | busAddr holds a capture |

## Verification
The hardest situation to reach is an escalated configurable fault arriving while the hard or NMI handler runs. This needs a fault that fails a preemption test at the same time as a hard-blocked handler identity, and it ends in lockup rather than in a hard dispatch. The random stimulus draws activeHandler over all seven codes and gives priorities and enables independent spreads, so these coincidences happen often. An occasional NMI releases each lockup, so the run keeps returning to dispatch. Directed steps beforehand force the stack-push exemption inside a disabled, same-class bus handler, and a fault during lockup with an address register free to capture.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [1:0] CLS_MEM   = 2'd0;
  localparam logic [1:0] CLS_BUS   = 2'd1;
  localparam logic [1:0] CLS_USAGE = 2'd2;
  localparam logic [1:0] CLS_HARD  = 2'd3;

  typedef enum logic [2:0] {
    ACT_THREAD = 3'd0,
    ACT_MEM    = 3'd1,
    ACT_BUS    = 3'd2,
    ACT_USAGE  = 3'd3,
    ACT_HARD   = 3'd4,
    ACT_NMI    = 3'd5,
    ACT_OTHER  = 3'd6
  } actId_e;

  // strobes from the decision logic to the status datapath
  typedef struct packed {
    logic capMem;
    logic capBus;
    logic setForced;
    logic setStackErr;
  } fecStrobes_t;
endpackage

// File: rtl/fec_ctrl.sv
module fec_ctrl
  import fec_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultReq,
  input  logic [1:0]        faultClass,
  input  logic              stackPush,
  input  logic [2:0]        classEnable,
  input  logic [PRIO_W-1:0] prioMem,
  input  logic [PRIO_W-1:0] prioBus,
  input  logic [PRIO_W-1:0] prioUsage,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic [2:0]        activeHandler,
  input  logic              nmiReq,
  output logic [3:0]        handlerSel,
  output logic              escalated,
  output logic              lockup,
  output fecStrobes_t       strobes
);
  logic              isCfg, sameClass, exempt, doEsc, toHard, hardBlocked;
  logic              accept, goLock;
  logic [PRIO_W-1:0] cfgPrio;
  logic [3:0]        nextSel;

  always_comb begin
    case (faultClass)
      CLS_MEM: cfgPrio = prioMem;
      CLS_BUS: cfgPrio = prioBus;
      default: cfgPrio = prioUsage;
    endcase
    isCfg       = (faultClass != CLS_HARD);
    sameClass   = (activeHandler == {1'b0, faultClass} + 3'd1);
    exempt      = (faultClass == CLS_BUS) && stackPush;
    doEsc       = isCfg && !exempt &&
                  (!classEnable[faultClass] || sameClass || (cfgPrio >= curPrio));
    toHard      = !isCfg || doEsc;
    hardBlocked = (activeHandler == ACT_HARD) || (activeHandler == ACT_NMI);
    accept      = faultReq && !lockup;
    goLock      = accept && toHard && hardBlocked;
    nextSel     = '0;
    if (accept && !goLock) begin
      if (toHard) nextSel = 4'b1000;
      else        nextSel[faultClass] = 1'b1;
    end
    strobes.capMem      = accept && (faultClass == CLS_MEM);
    strobes.capBus      = accept && (faultClass == CLS_BUS);
    strobes.setForced   = accept && doEsc;
    strobes.setStackErr = accept && exempt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      handlerSel <= '0;
      escalated  <= 1'b0;
      lockup     <= 1'b0;
    end else begin
      handlerSel <= nextSel;
      escalated  <= accept && doEsc;
      if (lockup) lockup <= !nmiReq;
      else        lockup <= goLock;
    end
  end

  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(handlerSel));
  p_sel_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (faultReq && !lockup) |=> ($countones(handlerSel) == 1) || $rose(lockup));
  p_idle_no_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    !faultReq |=> (handlerSel == 4'b0000));
  p_stack_exempt_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultReq && !lockup && faultClass == CLS_BUS && stackPush)
      |=> (handlerSel == 4'b0010) && !escalated);
  p_lock_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lockup && nmiReq) |=> !lockup);
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lockup && !nmiReq) |=> lockup && (handlerSel == 4'b0000));
  p_lock_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockup) |-> (handlerSel == 4'b0000));
endmodule

// File: rtl/fec_status.sv
module fec_status
  import fec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fecStrobes_t       strobes,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              clrForced,
  input  logic              clrStackErr,
  input  logic              clrMemAddr,
  input  logic              clrBusAddr,
  output logic              forcedEsc,
  output logic              stackErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memAddrValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrValid
);
  localparam int NUM_AREG = 2;

  logic [NUM_AREG-1:0]             capVec, clrVec, validVec;
  logic [NUM_AREG-1:0][ADDR_W-1:0] addrVec;

  assign capVec = {strobes.capBus, strobes.capMem};
  assign clrVec = {clrBusAddr, clrMemAddr};

  for (genvar g = 0; g < NUM_AREG; g++) begin : g_areg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        addrVec[g]  <= '0;
      end else if (capVec[g] && !validVec[g]) begin
        validVec[g] <= 1'b1;
        addrVec[g]  <= faultAddr;
      end else if (clrVec[g]) begin
        validVec[g] <= 1'b0;
      end
    end
  end

  assign memAddr      = addrVec[0];
  assign busAddr      = addrVec[1];
  assign memAddrValid = validVec[0];
  assign busAddrValid = validVec[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forcedEsc <= 1'b0;
      stackErr  <= 1'b0;
    end else begin
      forcedEsc <= strobes.setForced   || (forcedEsc && !clrForced);
      stackErr  <= strobes.setStackErr || (stackErr && !clrStackErr);
    end
  end

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memAddrValid && !clrMemAddr) |=> memAddrValid && $stable(memAddr));
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrValid && !clrBusAddr) |=> busAddrValid && $stable(busAddr));
  p_forced_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (forcedEsc && !clrForced) |=> forcedEsc);
  p_stack_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stackErr && !clrStackErr) |=> stackErr);
endmodule

// File: rtl/fault_escalation_ctrl.sv
module fault_escalation_ctrl
  import fec_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultReq,
  input  logic [1:0]        faultClass,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              stackPush,
  input  logic [2:0]        classEnable,
  input  logic [PRIO_W-1:0] prioMem,
  input  logic [PRIO_W-1:0] prioBus,
  input  logic [PRIO_W-1:0] prioUsage,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic [2:0]        activeHandler,
  input  logic              nmiReq,
  input  logic              clrForced,
  input  logic              clrStackErr,
  input  logic              clrMemAddr,
  input  logic              clrBusAddr,
  output logic [3:0]        handlerSel,
  output logic              escalated,
  output logic              lockup,
  output logic              forcedEsc,
  output logic              stackErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memAddrValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrValid
);
  fecStrobes_t strobes;

  fec_ctrl #(.PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .faultReq(faultReq), .faultClass(faultClass),
    .stackPush(stackPush), .classEnable(classEnable), .prioMem(prioMem),
    .prioBus(prioBus), .prioUsage(prioUsage), .curPrio(curPrio),
    .activeHandler(activeHandler), .nmiReq(nmiReq), .handlerSel(handlerSel),
    .escalated(escalated), .lockup(lockup), .strobes(strobes)
  );

  fec_status #(.ADDR_W(ADDR_W)) u_status (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultAddr(faultAddr),
    .clrForced(clrForced), .clrStackErr(clrStackErr), .clrMemAddr(clrMemAddr),
    .clrBusAddr(clrBusAddr), .forcedEsc(forcedEsc), .stackErr(stackErr),
    .memAddr(memAddr), .memAddrValid(memAddrValid), .busAddr(busAddr),
    .busAddrValid(busAddrValid)
  );
endmodule

// File: tb/tb_fault_escalation_ctrl.sv
`timescale 1ns/1ps
module tb_fault_escalation_ctrl;
  localparam int PW = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultReq = 0, stackPush = 0, nmiReq = 0;
  logic clrForced = 0, clrStackErr = 0, clrMemAddr = 0, clrBusAddr = 0;
  logic [1:0] faultClass = 0;
  logic [AW-1:0] faultAddr = 0;
  logic [2:0] classEnable = 0, activeHandler = 0;
  logic [PW-1:0] prioMem = 0, prioBus = 0, prioUsage = 0, curPrio = 0;
  logic [3:0] handlerSel;
  logic escalated, lockup, forcedEsc, stackErr, memAddrValid, busAddrValid;
  logic [AW-1:0] memAddr, busAddr;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic mLock = 0, mForced = 0, mStack = 0, mMemV = 0, mBusV = 0;
  logic [AW-1:0] mMemA = 0, mBusA = 0;

  always #2 clk = ~clk;

  fault_escalation_ctrl #(.PRIO_W(PW), .ADDR_W(AW)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: expected values from the requirements, then compare
  task automatic cycle();
    logic [PW-1:0] p;
    logic acc, ex, esc, hard, blk, lockNow;
    logic [3:0] eSel;
    string tag;
    p = (faultClass == 0) ? prioMem : (faultClass == 1) ? prioBus : prioUsage;
    acc  = faultReq && !mLock;
    ex   = (faultClass == 1) && stackPush;
    esc  = (faultClass != 3) && !ex &&
           (!classEnable[faultClass] || activeHandler == faultClass + 3'd1 || p >= curPrio);
    hard = (faultClass == 3) || esc;
    blk  = (activeHandler == 3'd4) || (activeHandler == 3'd5);
    lockNow = acc && hard && blk;
    eSel = 4'b0000;
    if (acc && !lockNow) eSel = hard ? 4'b1000 : (4'b0001 << faultClass);
    if (mLock) tag = "R9";
    else if (!faultReq) tag = "R2";
    else if (lockNow || faultClass == 3) tag = "R8";
    else if (ex) tag = "R7";
    else if (!classEnable[faultClass]) tag = "R6";
    else if (activeHandler == faultClass + 3'd1) tag = "R4";
    else if (p >= curPrio) tag = "R5";
    else tag = "R3";
    mLock = mLock ? !nmiReq : lockNow;
    mForced = (acc && esc) || (mForced && !clrForced);
    mStack  = (acc && ex) || (mStack && !clrStackErr);
    if (acc && faultClass == 0 && !mMemV) begin mMemV = 1; mMemA = faultAddr; end
    else if (clrMemAddr) mMemV = 0;
    if (acc && faultClass == 1 && !mBusV) begin mBusV = 1; mBusA = faultAddr; end
    else if (clrBusAddr) mBusV = 0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " sel/esc"}, {handlerSel, escalated}, {eSel, acc && esc});
    chk("R9 lockup", lockup, mLock);
    chk("R11 forcedEsc", forcedEsc, mForced);
    chk("R7 stackErr", stackErr, mStack);
    chk("R10 memAddr", {memAddrValid, mMemV ? memAddr : '0}, {mMemV, mMemV ? mMemA : '0});
    chk("R10 busAddr", {busAddrValid, mBusV ? busAddr : '0}, {mBusV, mBusV ? mBusA : '0});
  endtask

  task automatic quiet();
    faultReq = 0; nmiReq = 0; stackPush = 0;
    clrForced = 0; clrStackErr = 0; clrMemAddr = 0; clrBusAddr = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_f00d));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {handlerSel, escalated, lockup, forcedEsc, stackErr, memAddrValid, busAddrValid}, '0);
    rstN = 1'b1;
    @(negedge clk);
    // R3 enabled mem fault in thread, urgent enough
    classEnable = 3'b111; prioMem = 2; prioBus = 3; prioUsage = 4; curPrio = 8;
    activeHandler = 0; faultReq = 1; faultClass = 0; faultAddr = 32'hA000_0010; cycle();
    // R10 second mem fault must not overwrite
    faultAddr = 32'hB000_0020; cycle();
    // R7 stack-push bus fault inside disabled, same-class bus handler
    quiet(); faultReq = 1; faultClass = 1; stackPush = 1; classEnable = 3'b101;
    activeHandler = 2; faultAddr = 32'hC000_0030; cycle();
    // R5 equal priority escalates
    quiet(); classEnable = 3'b111; activeHandler = 6; faultReq = 1; faultClass = 2;
    prioUsage = 8; cycle();
    // R8 hard fault in hard handler -> lockup, then R9 fault ignored during lockup
    quiet(); faultReq = 1; faultClass = 3; activeHandler = 4; cycle();
    clrBusAddr = 1; cycle();
    quiet(); faultReq = 1; faultClass = 1; faultAddr = 32'hD000_0040; cycle();
    // R9 NMI exits lockup
    quiet(); nmiReq = 1; cycle();
    quiet(); clrForced = 1; clrStackErr = 1; clrMemAddr = 1; cycle();
    quiet();
    for (int i = 0; i < 3000; i++) begin
      faultReq    = ($urandom_range(9) < 6);
      faultClass  = 2'($urandom_range(3));
      faultAddr   = $urandom;
      stackPush   = ($urandom_range(4) == 0);
      classEnable = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b111;
      prioMem     = PW'($urandom); prioBus = PW'($urandom); prioUsage = PW'($urandom);
      curPrio     = PW'($urandom);
      activeHandler = 3'($urandom_range(6));
      nmiReq      = ($urandom_range(19) == 0);
      clrForced   = ($urandom_range(9) == 0);
      clrStackErr = ($urandom_range(9) == 0);
      clrMemAddr  = ($urandom_range(7) == 0);
      clrBusAddr  = ($urandom_range(7) == 0);
      cycle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule